// File: doc/BRIEF.md
# Transaction Lock and Page Protection Checker

This block gives the verdict on one load or store against an already translated page. It takes the control bits of the segment, the access fields of the page, and the byte offset of the access inside the page. When the segment is marked as transaction-locked, the block first compares the page's owner id with the id of the transaction that is running now. If they are equal, it picks the one lock bit that covers the 128-byte line being accessed. A single per-page mode bit then decides whether that bit is read as a read lock or as a write lock. When the segment is not transaction-locked, a two-bit page protection code and a one-bit segment key give no access, read only, or read/write for the page.

The request is captured in one register stage. The verdict is then formed combinationally from the captured request and the running-transaction id register. One of three outputs is raised: grant, lock fault or protection fault. The supervisor switches the running transaction by writing the id register through a dedicated write port. No other state has to change.

Top module: `access_guard`

## Requirements
- R1: After reset, grant, lock fault and protection fault are all 0 and the running-transaction id reads 0.
- R2: A request presented with `acc_valid` high on a rising clock edge is judged by the outputs in the following cycle. In any cycle that follows an edge with `acc_valid` low, all three outputs are 0.
- R3: For a locked segment (`seg_locked`=1), if the running-transaction id differs from `page_owner`, the access raises lock fault whatever the lock bits and mode bit hold.
- R4: For a locked segment with matching ids, a load is granted when the selected lock bit is 1 or `page_wmode` is 1. Otherwise it raises lock fault.
- R5: For a locked segment with matching ids, a store is granted only when both the selected lock bit and `page_wmode` are 1. Otherwise it raises lock fault.
- R6: The lock bit for an access is `page_lines[acc_offset[10:7]]`. Offset bits [6:0] do not affect the verdict.
- R7: For an unlocked segment with `seg_key`=0, `page_prot` codes 00, 01 and 10 grant loads and stores. Code 11 grants loads and gives protection fault on stores.
- R8: For an unlocked segment with `seg_key`=1, code 00 gives protection fault on every access. Codes 01 and 11 grant loads and give protection fault on stores. Code 10 grants both.
- R9: Every judged access raises exactly one of the three outputs. For an unlocked segment, lock fault is never raised, and the id compare and the lock bits have no effect.
- R10: A write with `tid_wr_en` high loads `tid_wr_data` into the running-transaction id register at the clock edge. `cur_tid` shows the new value from then on, and later locked accesses compare against it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request present |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_offset | input | 11 | Byte offset of the access inside the page |
| seg_locked | input | 1 | Segment uses transaction locking |
| seg_key | input | 1 | Segment key for page protection |
| page_owner | input | 8 | Transaction id recorded in the page entry |
| page_wmode | input | 1 | 1 = lock bits are write locks |
| page_lines | input | 16 | One lock bit per 128-byte line |
| page_prot | input | 2 | Page protection code |
| tid_wr_en | input | 1 | Write strobe for the running-transaction id |
| tid_wr_data | input | 8 | New running-transaction id |
| cur_tid | output | 8 | Current running-transaction id |
| grant | output | 1 | Access allowed |
| lock_fault | output | 1 | Access refused by transaction locking |
| prot_fault | output | 1 | Access refused by page protection |

## Verification
The assertions assume that the page fields, segment bits and offset that come with a request are stable and belong to that request at the capture edge. They also assume that an id write and the locked access that depends on it are not issued on the same edge. The bench drives every field on the falling edge, so each request is whole at the capture edge. It always gives an id write its own cycle before the accesses that rely on it. Under these rules the one-verdict and mismatch properties can be read from the captured request alone.

// File: rtl/access_guard_pkg.sv
package access_guard_pkg;

    // Outcome of judging one access
    typedef enum logic [1:0] {
        VERD_NONE  = 2'd0,
        VERD_GRANT = 2'd1,
        VERD_LOCK  = 2'd2,
        VERD_PROT  = 2'd3
    } verdict_e;

    // Rights a page grants under plain page protection
    typedef enum logic [1:0] {
        RIGHT_NONE = 2'd0,
        RIGHT_RO   = 2'd1,
        RIGHT_RW   = 2'd2
    } right_e;

    // Page rights from segment key and page protection code
    function automatic right_e page_rights(input logic key, input logic [1:0] code);
        right_e r;
        case (code)
            2'b00:   r = key ? RIGHT_NONE : RIGHT_RW;
            2'b01:   r = key ? RIGHT_RO   : RIGHT_RW;
            2'b10:   r = RIGHT_RW;
            default: r = RIGHT_RO;
        endcase
        return r;
    endfunction

    // Lock rule for one line once the owner matches
    function automatic logic line_permits(input logic lockbit, input logic wmode,
                                          input logic is_store);
        return is_store ? (lockbit & wmode) : (lockbit | wmode);
    endfunction

endpackage

// File: rtl/ag_tid_reg.sv
module ag_tid_reg #(
    parameter int TID_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [TID_W-1:0] wr_data,
    output logic [TID_W-1:0] tid_q
);

    always_ff @(posedge clk) begin
        if (rst)
            tid_q <= '0;
        else if (wr_en)
            tid_q <= wr_data;
    end

    AST_TID_LOADS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (tid_q == $past(wr_data)));  // R10

    AST_TID_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !$past(rst)) |=> $stable(tid_q));  // R10

endmodule

// File: rtl/ag_req_stage.sv
module ag_req_stage #(
    parameter int TID_W = 8,
    parameter int IDX_W = 4,
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic             store_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             locked_i,
    input  logic             key_i,
    input  logic [TID_W-1:0] owner_i,
    input  logic             wmode_i,
    input  logic [LINES-1:0] lines_i,
    input  logic [1:0]       prot_i,
    output logic             valid_q,
    output logic             store_q,
    output logic [IDX_W-1:0] idx_q,
    output logic             locked_q,
    output logic             key_q,
    output logic [TID_W-1:0] owner_q,
    output logic             wmode_q,
    output logic [LINES-1:0] lines_q,
    output logic [1:0]       prot_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            store_q  <= 1'b0;
            idx_q    <= '0;
            locked_q <= 1'b0;
            key_q    <= 1'b0;
            owner_q  <= '0;
            wmode_q  <= 1'b0;
            lines_q  <= '0;
            prot_q   <= '0;
        end else begin
            valid_q  <= valid_i;
            store_q  <= store_i;
            idx_q    <= idx_i;
            locked_q <= locked_i;
            key_q    <= key_i;
            owner_q  <= owner_i;
            wmode_q  <= wmode_i;
            lines_q  <= lines_i;
            prot_q   <= prot_i;
        end
    end

endmodule

// File: rtl/ag_lock_judge.sv
module ag_lock_judge
    import access_guard_pkg::*;
#(
    parameter int TID_W = 8,
    parameter int IDX_W = 4,
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [TID_W-1:0] run_tid,
    input  logic [TID_W-1:0] owner,
    input  logic             wmode,
    input  logic [LINES-1:0] lines,
    input  logic [IDX_W-1:0] idx,
    input  logic             is_store,
    output verdict_e         verdict
);

    logic owner_match;
    logic sel_bit;

    assign owner_match = (run_tid == owner);
    assign sel_bit     = lines[idx];

    always_comb begin
        if (!owner_match)
            verdict = VERD_LOCK;
        else if (line_permits(sel_bit, wmode, is_store))
            verdict = VERD_GRANT;
        else
            verdict = VERD_LOCK;
    end

    AST_STORE_NEEDS_W: assert property (@(posedge clk) disable iff (rst)
        (active && is_store && verdict == VERD_GRANT) |-> (wmode && lines[idx]));  // R5

    AST_LOCK_NEVER_PROT: assert property (@(posedge clk) disable iff (rst)
        active |-> (verdict != VERD_PROT && verdict != VERD_NONE));  // R9

endmodule

// File: rtl/ag_prot_judge.sv
module ag_prot_judge
    import access_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       key,
    input  logic [1:0] code,
    input  logic       is_store,
    output verdict_e   verdict
);

    right_e rights;

    assign rights = page_rights(key, code);

    always_comb begin
        case (rights)
            RIGHT_RW: verdict = VERD_GRANT;
            RIGHT_RO: verdict = is_store ? VERD_PROT : VERD_GRANT;
            default:  verdict = VERD_PROT;
        endcase
    end

    AST_NOACCESS_PAGE: assert property (@(posedge clk) disable iff (rst)
        (active && key && code == 2'b00) |-> (verdict == VERD_PROT));  // R8

    AST_RW_CODE_GRANTS: assert property (@(posedge clk) disable iff (rst)
        (active && code == 2'b10) |-> (verdict == VERD_GRANT));  // R7

endmodule

// File: rtl/access_guard.sv
module access_guard
    import access_guard_pkg::*;
#(
    parameter int TID_W     = 8,
    parameter int OFF_W     = 11,
    parameter int LINE_LSB  = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        acc_valid,
    input  logic                        acc_store,
    input  logic [OFF_W-1:0]            acc_offset,
    input  logic                        seg_locked,
    input  logic                        seg_key,
    input  logic [TID_W-1:0]            page_owner,
    input  logic                        page_wmode,
    input  logic [(1<<(OFF_W-LINE_LSB))-1:0] page_lines,
    input  logic [1:0]                  page_prot,
    input  logic                        tid_wr_en,
    input  logic [TID_W-1:0]            tid_wr_data,
    output logic [TID_W-1:0]            cur_tid,
    output logic                        grant,
    output logic                        lock_fault,
    output logic                        prot_fault
);

    localparam int IDX_W = OFF_W - LINE_LSB;
    localparam int LINES = 1 << IDX_W;

    logic             valid_q, store_q, locked_q, key_q, wmode_q;
    logic [IDX_W-1:0] idx_q;
    logic [TID_W-1:0] owner_q;
    logic [LINES-1:0] lines_q;
    logic [1:0]       prot_q;
    logic             unused_low_offset;
    verdict_e         lock_v, prot_v, final_v;

    // Bits below the line boundary play no part in the decision
    assign unused_low_offset = ^acc_offset[LINE_LSB-1:0];

    ag_tid_reg #(.TID_W(TID_W)) u_tid (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tid_wr_en),
        .wr_data (tid_wr_data),
        .tid_q   (cur_tid)
    );

    ag_req_stage #(.TID_W(TID_W), .IDX_W(IDX_W), .LINES(LINES)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (acc_valid),
        .store_i  (acc_store),
        .idx_i    (acc_offset[OFF_W-1:LINE_LSB]),
        .locked_i (seg_locked),
        .key_i    (seg_key),
        .owner_i  (page_owner),
        .wmode_i  (page_wmode),
        .lines_i  (page_lines),
        .prot_i   (page_prot),
        .valid_q  (valid_q),
        .store_q  (store_q),
        .idx_q    (idx_q),
        .locked_q (locked_q),
        .key_q    (key_q),
        .owner_q  (owner_q),
        .wmode_q  (wmode_q),
        .lines_q  (lines_q),
        .prot_q   (prot_q)
    );

    ag_lock_judge #(.TID_W(TID_W), .IDX_W(IDX_W), .LINES(LINES)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .active   (valid_q && locked_q),
        .run_tid  (cur_tid),
        .owner    (owner_q),
        .wmode    (wmode_q),
        .lines    (lines_q),
        .idx      (idx_q),
        .is_store (store_q),
        .verdict  (lock_v)
    );

    ag_prot_judge u_prot (
        .clk      (clk),
        .rst      (rst),
        .active   (valid_q && !locked_q),
        .key      (key_q),
        .code     (prot_q),
        .is_store (store_q),
        .verdict  (prot_v)
    );

    always_comb begin
        if (!valid_q)
            final_v = VERD_NONE;
        else if (locked_q)
            final_v = lock_v;
        else
            final_v = prot_v;
    end

    assign grant      = (final_v == VERD_GRANT);
    assign lock_fault = (final_v == VERD_LOCK);
    assign prot_fault = (final_v == VERD_PROT);

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> ($countones({grant, lock_fault, prot_fault}) == 1));  // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> !(grant || lock_fault || prot_fault));  // R2

    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> (grant || lock_fault || prot_fault));  // R2

    AST_MISMATCH_LOCK: assert property (@(posedge clk) disable iff (rst)
        (valid_q && locked_q && cur_tid != owner_q) |-> lock_fault);  // R3

    AST_UNLOCKED_NO_LOCKFAULT: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !locked_q) |-> !lock_fault);  // R9

endmodule

// File: tb/sim_access_guard.sv
module sim_access_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_store = 1'b0;
    logic [10:0] acc_offset = '0;
    logic        seg_locked = 1'b0;
    logic        seg_key = 1'b0;
    logic [7:0]  page_owner = '0;
    logic        page_wmode = 1'b0;
    logic [15:0] page_lines = '0;
    logic [1:0]  page_prot = '0;
    logic        tid_wr_en = 1'b0;
    logic [7:0]  tid_wr_data = '0;
    logic [7:0]  cur_tid;
    logic        grant, lock_fault, prot_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    access_guard u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_store(acc_store),
        .acc_offset(acc_offset), .seg_locked(seg_locked), .seg_key(seg_key),
        .page_owner(page_owner), .page_wmode(page_wmode), .page_lines(page_lines),
        .page_prot(page_prot), .tid_wr_en(tid_wr_en), .tid_wr_data(tid_wr_data),
        .cur_tid(cur_tid), .grant(grant), .lock_fault(lock_fault), .prot_fault(prot_fault)
    );

    // expected outputs packed as {grant, lock_fault, prot_fault}
    task automatic check_out(input logic [2:0] exp, input string req);
        checks++;
        if ({grant, lock_fault, prot_fault} !== exp) begin
            fails++;
            $display("FAIL %s: got g/l/p=%b expected %b", req, {grant, lock_fault, prot_fault}, exp);
        end
    endtask

    task automatic check_tid(input logic [7:0] exp, input string req);
        checks++;
        if (cur_tid !== exp) begin
            fails++;
            $display("FAIL %s: cur_tid=%0h expected %0h", req, cur_tid, exp);
        end
    endtask

    // Drive one access at a falling edge, judge it one cycle later
    task automatic access(input logic st, input logic lk, input logic key,
                          input logic [1:0] pp, input logic [7:0] owner,
                          input logic w, input logic [15:0] lines,
                          input logic [10:0] off, input logic [2:0] exp,
                          input string req);
        acc_valid  = 1'b1;
        acc_store  = st;
        seg_locked = lk;
        seg_key    = key;
        page_prot  = pp;
        page_owner = owner;
        page_wmode = w;
        page_lines = lines;
        acc_offset = off;
        @(negedge clk);
        acc_valid = 1'b0;
        check_out(exp, req);
    endtask

    task automatic write_tid(input logic [7:0] v);
        tid_wr_en   = 1'b1;
        tid_wr_data = v;
        @(negedge clk);
        tid_wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] run_id;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet after reset
        check_out(3'b000, "R1 reset outputs");
        check_tid(8'h00, "R1 reset id");

        // R10: id write is visible next cycle
        write_tid(8'h5A);
        check_tid(8'h5A, "R10 id write");
        run_id = 8'h5A;

        // R3..R6: exhaustive over line, lock bit, W, store, owner match
        for (int ln = 0; ln < 16; ln++) begin
            for (int bv = 0; bv < 2; bv++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int st = 0; st < 2; st++) begin
                        for (int m = 0; m < 2; m++) begin
                            logic [15:0] lines;
                            logic [10:0] off;
                            logic [7:0]  owner;
                            logic        ok;
                            lines = (bv != 0) ? (16'h1 << ln) : ~(16'h1 << ln);
                            off   = {ln[3:0], 7'((ln * 37 + bv * 11 + st * 5) % 128)};
                            owner = (m != 0) ? run_id : (run_id ^ 8'((ln % 7) + 1));
                            ok    = (m != 0) && ((st != 0) ? (bv != 0 && w != 0) : (bv != 0 || w != 0));
                            access(st[0], 1'b1, ln[0], 2'((ln + st) % 4), owner, w[0], lines, off,
                                   ok ? 3'b100 : 3'b010,
                                   (m == 0) ? "R3 owner mismatch" :
                                   (st != 0) ? "R5 locked store R6 line select" :
                                               "R4 locked load R6 line select");
                        end
                    end
                end
            end
        end

        // R2: idle cycle gives no verdict
        @(negedge clk);
        check_out(3'b000, "R2 idle quiet");

        // R7, R8, R9: all keys, codes, directions; ids and lock bits set to refuse
        for (int key = 0; key < 2; key++) begin
            for (int pp = 0; pp < 4; pp++) begin
                for (int st = 0; st < 2; st++) begin
                    int rights; // 0 none, 1 read only, 2 read/write
                    logic ok;
                    if (key == 0) rights = (pp == 3) ? 1 : 2;
                    else          rights = (pp == 0) ? 0 : (pp == 2) ? 2 : 1;
                    ok = (rights == 2) || (rights == 1 && st == 0);
                    access(st[0], 1'b0, key[0], pp[1:0], ~run_id, 1'b0, 16'h0000,
                           11'(pp * 300 + st * 77), ok ? 3'b100 : 3'b001,
                           (key == 0) ? "R7 key0 protection R9" : "R8 key1 protection R9");
                end
            end
        end

        // R2: back-to-back requests each judged in their own cycle
        access(1'b0, 1'b0, 1'b1, 2'b00, 8'h00, 1'b0, 16'h0, 11'h0, 3'b001, "R2 back-to-back a");
        access(1'b1, 1'b1, 1'b0, 2'b00, run_id, 1'b1, 16'hFFFF, 11'h7FF, 3'b100, "R2 back-to-back b");

        // R10: switch transaction; old owner now mismatches, new owner matches
        write_tid(8'hC3);
        check_tid(8'hC3, "R10 id rewrite");
        access(1'b0, 1'b1, 1'b0, 2'b00, 8'h5A, 1'b1, 16'hFFFF, 11'h080, 3'b010, "R10 old owner refused");
        access(1'b1, 1'b1, 1'b0, 2'b00, 8'hC3, 1'b1, 16'h0002, 11'h0FF, 3'b100, "R10 new owner granted");

        // R1: reset in mid-run clears id and outputs
        acc_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        rst = 1'b0;
        check_out(3'b000, "R1 reset outputs again");
        check_tid(8'h00, "R1 reset id again");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule